// File: doc/BRIEF.md
# Interrupt Priority Bank with Non-Secure View

This block holds one 8-bit priority per private interrupt (32 by default) and serves register accesses to them. Each access is either a single byte or a 32-bit word, is a read or a write, and carries a secure or non-secure attribute. The full priority array is driven continuously to a downstream priority selector, which decides which interrupt wins. That selector is not part of this block.

A secure access reads and writes the stored byte unchanged. So does any access while the security-disable input is high. With security enabled, a non-secure access sees each interrupt differently depending on its group bit, which comes in on an input bitmap:
- If the group bit is 0, the interrupt belongs to the secure group. Its byte reads as zero and ignores writes.
- If the group bit is 1, the non-secure view is halved. A read returns the stored value shifted up one bit. A write stores the value shifted down one bit with the most significant bit forced to 1.

In a word access every byte lane is judged on its own.

Read responses and the error flag are registered and appear one cycle after the access. Writes update the array at the same clock edge, so the new value shows on the priority output one cycle after the access.

Top module: `prio_bank`

## Requirements
- R1: While reset is low, every priority is zero and neither `rd_valid` nor `acc_err` is set.
- R2: Byte offset n of the window holds the priority of interrupt n. The value of interrupt n appears on `prio_out[8n+7:8n]` one cycle after a write to it.
- R3: `rd_valid` is high in exactly the cycle after a cycle with `acc_valid`=1 and `acc_write`=0.
- R4: A secure access (`acc_secure`=1), or any access while `sec_disable`=1, reads and writes the raw 8-bit value.
- R5: With security enabled, a non-secure read of an interrupt whose group bit is 1 returns the stored value shifted left by one, truncated to 8 bits.
- R6: With security enabled, a non-secure write to an interrupt whose group bit is 1 stores 0x80 OR (written byte shifted right by one).
- R7: With security enabled, a non-secure access to an interrupt whose group bit is 0 reads 0 for that byte and leaves that byte unchanged on write.
- R8: A word access (`acc_word`=1) at offset n covers interrupts n to n+3, with interrupt n in bits 7:0. Each lane is checked and converted on its own.
- R9: A word access with `acc_offset[1:0]` not 00 raises `acc_err` in the next cycle, changes no priority, and reads as 0.
- R10: A byte access uses bits 7:0 of `acc_wdata` and returns its value in `rd_data[7:0]` with bits 31:8 zero. It touches only the addressed byte.
- R11: In a cycle without a write access, no priority changes in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| acc_secure | input | 1 | 1 = secure access |
| acc_offset | input | 5 | Byte offset within the priority window |
| acc_wdata | input | 32 | Write data |
| grp_bits | input | 32 | Group bit per interrupt, 1 = non-secure group |
| sec_disable | input | 1 | 1 = security disabled, all accesses raw |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| acc_err | output | 1 | Previous access was a misaligned word |
| prio_out | output | 256 | All priorities, interrupt n at bits 8n+7:8n |

## Verification
Every access result is due exactly one cycle after the access is presented: `rd_valid`, `rd_data` and `acc_err` for reads, and the updated byte on `prio_out` for writes. The bench drives each access at a falling edge. It checks all outputs at the next falling edge against a behavioural model that was updated when the access was issued. Idle cycles are also compared, to confirm that `prio_out` holds and that no response appears. Secure-group lanes, shifted views, mixed-group word writes, window edges and misaligned words are each driven on their own.

// File: rtl/prio_bank_pkg.sv
package prio_bank_pkg;

    // Non-secure view of a stored priority: one bit of resolution lost at the top.
    function automatic logic [7:0] ns_read_view(input logic [7:0] stored);
        return {stored[6:0], 1'b0};
    endfunction

    // Non-secure write maps into the lower-priority half of the range.
    function automatic logic [7:0] ns_write_view(input logic [7:0] wbyte);
        return {1'b1, wbyte[7:1]};
    endfunction

endpackage

// File: rtl/prio_bank_decode.sv
module prio_bank_decode #(
    parameter  int NUM_IRQ = 32,
    parameter  int LANES   = 4,
    localparam int IDX_W   = $clog2(NUM_IRQ),
    localparam int LANE_W  = $clog2(LANES)
) (
    input  logic             acc_valid,
    input  logic             acc_word,
    input  logic [IDX_W-1:0] acc_offset,
    output logic [LANES-1:0] lane_en,
    output logic [IDX_W-1:0] base_idx,
    output logic             misalign
);
    logic [LANE_W-1:0] lane_sel;

    assign lane_sel = acc_offset[LANE_W-1:0];
    assign base_idx = {acc_offset[IDX_W-1:LANE_W], {LANE_W{1'b0}}};

    always_comb begin
        misalign = acc_valid && acc_word && (lane_sel != '0);
        if (!acc_valid || misalign) begin
            lane_en = '0;
        end else if (acc_word) begin
            lane_en = '1;
        end else begin
            lane_en = LANES'(1) << lane_sel;
        end
    end
endmodule

// File: rtl/prio_lane_view.sv
module prio_lane_view
    import prio_bank_pkg::*;
(
    input  logic [7:0] stored,
    input  logic [7:0] wbyte,
    input  logic       grp,
    input  logic       ns_restrict,
    output logic       visible,
    output logic [7:0] rd_view,
    output logic [7:0] wr_value
);
    always_comb begin
        visible  = !ns_restrict || grp;
        rd_view  = '0;
        wr_value = wbyte;
        if (ns_restrict) begin
            wr_value = ns_write_view(wbyte);
            if (grp) begin
                rd_view = ns_read_view(stored);
            end
        end else begin
            rd_view = stored;
        end
    end
endmodule

// File: rtl/prio_bank.sv
module prio_bank #(
    parameter  int NUM_IRQ = 32,
    parameter  int PRIO_W  = 8,
    parameter  int LANES   = 4,
    localparam int IDX_W   = $clog2(NUM_IRQ),
    localparam int DATA_W  = LANES * PRIO_W,
    localparam int FLAT_W  = NUM_IRQ * PRIO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic               acc_word,
    input  logic               acc_secure,
    input  logic [IDX_W-1:0]   acc_offset,
    input  logic [DATA_W-1:0]  acc_wdata,
    input  logic [NUM_IRQ-1:0] grp_bits,
    input  logic               sec_disable,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data,
    output logic               acc_err,
    output logic [FLAT_W-1:0]  prio_out
);
    typedef struct packed {
        logic [NUM_IRQ-1:0][PRIO_W-1:0] prio;
        logic                           rsp_valid;
        logic [DATA_W-1:0]              rsp_data;
        logic                           rsp_err;
    } state_t;

    state_t st_d, st_q;

    logic [LANES-1:0]             lane_en;
    logic [IDX_W-1:0]             base_idx;
    logic                         misalign;
    logic                         ns_restrict;
    logic [LANES-1:0]             lane_vis;
    logic [LANES-1:0][PRIO_W-1:0] lane_st;
    logic [LANES-1:0][PRIO_W-1:0] lane_rd;
    logic [LANES-1:0][PRIO_W-1:0] lane_wr;

    assign ns_restrict = !acc_secure && !sec_disable;

    prio_bank_decode #(
        .NUM_IRQ (NUM_IRQ),
        .LANES   (LANES)
    ) u_decode (
        .acc_valid  (acc_valid),
        .acc_word   (acc_word),
        .acc_offset (acc_offset),
        .lane_en    (lane_en),
        .base_idx   (base_idx),
        .misalign   (misalign)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [IDX_W-1:0]  idx;
        logic [PRIO_W-1:0] wbyte;

        assign idx        = base_idx + IDX_W'(k);
        assign lane_st[k] = st_q.prio[idx];
        assign wbyte      = acc_word ? acc_wdata[k*PRIO_W +: PRIO_W]
                                     : acc_wdata[PRIO_W-1:0];

        prio_lane_view u_view (
            .stored      (lane_st[k]),
            .wbyte       (wbyte),
            .grp         (grp_bits[idx]),
            .ns_restrict (ns_restrict),
            .visible     (lane_vis[k]),
            .rd_view     (lane_rd[k]),
            .wr_value    (lane_wr[k])
        );
    end

    always_comb begin
        logic [PRIO_W-1:0]            byte_rd;
        logic [LANES-1:0][PRIO_W-1:0] word_rd;

        st_d           = st_q;
        st_d.rsp_valid = acc_valid && !acc_write;
        st_d.rsp_err   = misalign;
        st_d.rsp_data  = '0;
        byte_rd        = '0;
        word_rd        = '0;

        for (int k = 0; k < LANES; k++) begin
            if (lane_en[k]) begin
                word_rd[k] = lane_rd[k];
                byte_rd    = lane_rd[k];
                if (acc_write && lane_vis[k]) begin
                    st_d.prio[base_idx + IDX_W'(k)] = lane_wr[k];
                end
            end
        end

        if (acc_valid && !acc_write) begin
            st_d.rsp_data = acc_word ? DATA_W'(word_rd) : DATA_W'(byte_rd);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid = st_q.rsp_valid;
    assign rd_data  = st_q.rsp_data;
    assign acc_err  = st_q.rsp_err;
    assign prio_out = st_q.prio;
endmodule

// File: rtl/prio_bank_chk.sv
module prio_bank_chk #(
    parameter  int NUM_IRQ = 32,
    parameter  int PRIO_W  = 8,
    parameter  int LANES   = 4,
    localparam int IDX_W   = $clog2(NUM_IRQ),
    localparam int LANE_W  = $clog2(LANES),
    localparam int DATA_W  = LANES * PRIO_W,
    localparam int FLAT_W  = NUM_IRQ * PRIO_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic               acc_write,
    input logic               acc_word,
    input logic               acc_secure,
    input logic [IDX_W-1:0]   acc_offset,
    input logic [DATA_W-1:0]  acc_wdata,
    input logic [NUM_IRQ-1:0] grp_bits,
    input logic               sec_disable,
    input logic               rd_valid,
    input logic [DATA_W-1:0]  rd_data,
    input logic               acc_err,
    input logic [FLAT_W-1:0]  prio_out
);
    logic                           past_ok;
    logic                           p_valid, p_write, p_word, p_ns, p_grp;
    logic [IDX_W-1:0]               p_off;
    logic [PRIO_W-1:0]              p_wbyte;
    logic [NUM_IRQ-1:0][PRIO_W-1:0] pv;
    logic                           rst_low_q = 1'b0;

    assign pv = prio_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
            p_valid <= 1'b0;
            p_write <= 1'b0;
            p_word  <= 1'b0;
            p_ns    <= 1'b0;
            p_grp   <= 1'b0;
            p_off   <= '0;
            p_wbyte <= '0;
        end else begin
            past_ok <= 1'b1;
            p_valid <= acc_valid;
            p_write <= acc_write;
            p_word  <= acc_word;
            p_ns    <= !acc_secure && !sec_disable;
            p_grp   <= grp_bits[acc_offset];
            p_off   <= acc_offset;
            p_wbyte <= acc_wdata[PRIO_W-1:0];
        end
    end

    always @(posedge clk) begin
        if (!rst_n && rst_low_q) begin
            assert_reset_clear_R1: assert (prio_out == '0 && !rd_valid && !acc_err);
        end
        rst_low_q <= !rst_n;
    end

    assert_rsp_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (rd_valid == (p_valid && !p_write)));

    assert_misalign_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && p_valid && p_word && (p_off[LANE_W-1:0] != '0)
        |-> acc_err && (rd_data == '0) && $stable(prio_out));

    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !(p_valid && p_write) |-> $stable(prio_out));

    assert_hidden_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && p_valid && !p_write && !p_word && p_ns && !p_grp |-> rd_data == '0);

    assert_hidden_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && p_valid && p_write && !p_word && p_ns && !p_grp |-> $stable(prio_out));

    assert_ns_write_conv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && p_valid && p_write && !p_word && p_ns && p_grp
        |-> pv[p_off] == {1'b1, p_wbyte[PRIO_W-1:1]});

    assert_byte_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && rd_valid && !p_word |-> rd_data[DATA_W-1:PRIO_W] == '0);
endmodule

bind prio_bank prio_bank_chk #(
    .NUM_IRQ (NUM_IRQ),
    .PRIO_W  (PRIO_W),
    .LANES   (LANES)
) u_chk (.*);

// File: tb/prio_bank_bench.sv
module prio_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NIRQ       = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         acc_valid = 1'b0, acc_write = 1'b0, acc_word = 1'b0, acc_secure = 1'b0;
    logic [4:0]   acc_offset = '0;
    logic [31:0]  acc_wdata = '0;
    logic [31:0]  grp_bits = '0;
    logic         sec_disable = 1'b0;
    logic         rd_valid, acc_err;
    logic [31:0]  rd_data;
    logic [255:0] prio_out;

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] ref_prio [NIRQ];

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_bank u_prio_bank (
        .clk, .rst_n, .acc_valid, .acc_write, .acc_word, .acc_secure,
        .acc_offset, .acc_wdata, .grp_bits, .sec_disable,
        .rd_valid, .rd_data, .acc_err, .prio_out
    );

    function automatic logic [255:0] ref_flat();
        logic [255:0] f = '0;
        for (int i = 0; i < NIRQ; i++) f[i*8 +: 8] = ref_prio[i];
        return f;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Compare every output against the model; called once per clock at the falling edge.
    task automatic compare(input string req, input logic erv, input logic [31:0] erd, input logic eerr);
        check(req, "rd_valid", 256'(rd_valid), 256'(erv));
        check(req, "rd_data",  256'(rd_data),  256'(erd));
        check(req, "acc_err",  256'(acc_err),  256'(eerr));
        check(req, "prio_out", prio_out,       ref_flat());
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        compare(req, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic access(input bit wr, input bit word, input bit sec, input int off,
                          input logic [31:0] wd, input string req);
        bit          ns;
        bit          err;
        logic [31:0] erd = '0;
        ns  = !sec && !sec_disable;
        err = word && (off % 4 != 0);
        acc_valid  = 1'b1;
        acc_write  = wr;
        acc_word   = word;
        acc_secure = sec;
        acc_offset = 5'(off);
        acc_wdata  = wd;
        if (!err) begin
            for (int j = 0; j < (word ? 4 : 1); j++) begin
                int         idx = off + j;
                logic [7:0] b   = word ? wd[j*8 +: 8] : wd[7:0];
                bit         hid = ns && !grp_bits[idx];
                if (wr) begin
                    if (!hid) ref_prio[idx] = ns ? (8'h80 | (b >> 1)) : b;
                end else begin
                    logic [7:0] v = ref_prio[idx] << 1;
                    erd[j*8 +: 8] = hid ? 8'h00 : (ns ? v : ref_prio[idx]);
                end
            end
        end
        @(negedge clk);
        acc_valid = 1'b0;
        compare(req, !wr, erd, err);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NIRQ; i++) ref_prio[i] = 8'h00;
        repeat (3) @(negedge clk);
        compare("R1", 1'b0, 32'h0, 1'b0);
        rst_n = 1'b1;
        idle("R1");

        // R4 / R2 / R10: secure raw byte writes at both window edges, then reads
        access(1, 0, 1, 0,  32'hFFFF_FFA5, "R4");
        access(1, 0, 1, 31, 32'h0000_003C, "R2");
        access(0, 0, 1, 31, 32'h0, "R10");
        access(0, 0, 1, 0,  32'h0, "R4");
        idle("R11");

        // R8: secure word write and read, lowest interrupt in bits 7:0
        access(1, 1, 1, 8,  32'h4433_2211, "R8");
        access(0, 1, 1, 8,  32'h0, "R8");
        access(0, 0, 1, 10, 32'h0, "R10");
        access(1, 1, 1, 28, 32'h9080_7060, "R8");
        access(0, 1, 1, 28, 32'h0, "R8");

        // Non-secure views with security enabled
        grp_bits = 32'h0F0F_3305;
        access(0, 0, 0, 0,  32'h0, "R5");
        access(0, 0, 0, 31, 32'h0, "R7");
        access(1, 0, 0, 31, 32'h0000_0011, "R7");
        access(0, 0, 1, 31, 32'h0, "R7");
        access(1, 0, 0, 2,  32'h0000_0064, "R6");
        access(0, 0, 1, 2,  32'h0, "R6");
        access(0, 0, 0, 2,  32'h0, "R5");
        access(1, 1, 0, 0,  32'hC3B2_A190, "R8");
        access(0, 1, 1, 0,  32'h0, "R8");
        access(0, 1, 0, 0,  32'h0, "R8");
        access(0, 1, 0, 8,  32'h0, "R5");
        access(1, 1, 0, 12, 32'hFFFF_FFFF, "R7");
        idle("R11");

        // R4: security disabled makes non-secure accesses raw
        sec_disable = 1'b1;
        access(1, 0, 0, 31, 32'h0000_0055, "R4");
        access(0, 0, 0, 31, 32'h0, "R4");
        access(1, 1, 0, 4,  32'h0102_0304, "R4");
        access(0, 1, 0, 4,  32'h0, "R4");
        sec_disable = 1'b0;

        // R9: misaligned word accesses
        access(0, 1, 1, 5,  32'h0, "R9");
        access(1, 1, 1, 6,  32'hDEAD_BEEF, "R9");
        access(1, 1, 0, 3,  32'h1234_5678, "R9");
        idle("R11");

        // R2: fill every byte with a pattern, read back by word
        for (int i = 0; i < NIRQ; i++) access(1, 0, 1, i, 32'(i * 7 + 3), "R2");
        for (int w = 0; w < NIRQ; w += 4) access(0, 1, 1, w, 32'h0, "R2");
        for (int w = 0; w < NIRQ; w += 4) access(0, 1, 0, w, 32'h0, "R8");
        idle("R3");

        finish_run();
    end
endmodule